// File: doc/BRIEF.md
# Sequential-Scan Associative Lookup Unit

This block models a content-addressable memory with ordinary single-ported storage and a small scanning controller. It does not compare every entry in one cycle. A lookup walks the entries from index 0 upward, one per clock, and stops at the first valid entry whose key equals the search key. If no entry matches, it stops at the highest index written since reset. Each entry holds a key and a valid flag. Write and invalidate requests reach the storage through the same single port, and each takes one clock.

The unit is meant for a performance model in which host clocks and model cycles are decoupled. A single-cycle completion pulse marks the point where the modelled lookup has resolved, so the model can advance its own time. The number of host clocks spent on the last lookup is reported beside the result, so that statistics can be gathered.

Top module: `scan_cam`

## Requirements
- R1: While reset is held and after it is released, `req_ready`=1, `done`=0, `hit`=0, `hit_idx`=0 and `lookup_clks`=0, and every entry is invalid.
- R2: A lookup reports `hit`=1 exactly when some valid entry holds a key equal to `req_key`. An invalid entry never matches.
- R3: On a hit, `hit_idx` is the lowest valid matching index. On a miss, `hit_idx` is 0.
- R4: `done` is a one-clock pulse. It is raised in the cycle after the last entry of a lookup is examined, and it is never raised for writes or invalidates.
- R5: `lookup_clks` equals the matching index plus 1 on a hit. On a miss it equals the high mark plus 1, where the high mark is the largest index written since reset (0 if none). The value therefore lies between 1 and DEPTH.
- R6: `req_ready` is 1 when the unit is idle. An accepted lookup holds it at 0 for `lookup_clks` cycles. An accepted write or invalidate leaves it at 1.
- R7: The operation codes are: `req_op`=0 looks up `req_key` (and `req_idx` is ignored), `req_op`=1 writes `req_key` into entry `req_idx` and makes the entry valid, and `req_op`=2 or 3 makes entry `req_idx` invalid.
- R8: `hit`, `hit_idx` and `lookup_clks` keep their values until the next lookup completes. Writes and invalidates do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_op | input | 2 | 0 lookup, 1 write, 2/3 invalidate |
| req_idx | input | IDX_W | Entry index for write or invalidate |
| req_key | input | KEY_W | Search key or key to store |
| done | output | 1 | Pulse: lookup resolved, model cycle may advance |
| hit | output | 1 | Last lookup found a match |
| hit_idx | output | IDX_W | Lowest matching index of the last lookup |
| lookup_clks | output | CNT_W | Host clocks spent by the last lookup |

## Verification
The bench builds the unit with DEPTH=8 and KEY_W=4. With only sixteen key values spread over eight slots, the same key often sits in several entries at once, so the lowest-index rule is exercised many times. A short directed run first covers these cases: a lookup on an empty array, a duplicate key, an invalidated lower duplicate, and a write to index 7. Together they produce the full eight-clock scan and scans of intermediate length. A long random run then mixes the three operations with idle cycles and with requests raised while the unit is busy.

// File: rtl/scan_cam.sv
module scan_cam #(
  parameter int KEY_W = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [KEY_W-1:0] req_key,
  output logic             done,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [CNT_W-1:0] lookup_clks
);

  typedef enum logic {IDLE, SCAN} state_t;
  state_t state;

  logic [DEPTH-1:0] vld;
  logic [KEY_W-1:0] keys [DEPTH];
  logic [IDX_W-1:0] ptr, top;
  logic [KEY_W-1:0] skey;

  wire accept = req_valid && req_ready;
  wire op_lkp = (req_op == 2'd0);
  wire op_wr  = (req_op == 2'd1);
  wire op_inv = req_op[1];

  // single access port: one address per clock
  wire [IDX_W-1:0] addr   = (state == SCAN) ? ptr : req_idx;
  wire             rd_vld = vld[addr];
  wire [KEY_W-1:0] rd_key = keys[addr];

  wire match = (state == SCAN) && rd_vld && (rd_key == skey);
  wire last  = match || (ptr == top);

  assign req_ready = (state == IDLE);

  always_ff @(posedge clk) begin
    if (accept && op_wr) keys[addr] <= req_key;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= IDLE;
      vld         <= '0;
      ptr         <= '0;
      top         <= '0;
      skey        <= '0;
      done        <= 1'b0;
      hit         <= 1'b0;
      hit_idx     <= '0;
      lookup_clks <= '0;
    end else begin
      done <= 1'b0;
      if (state == IDLE) begin
        if (accept) begin
          if (op_wr) begin
            vld[addr] <= 1'b1;
            if (req_idx > top) top <= req_idx;
          end else if (op_inv) begin
            vld[addr] <= 1'b0;
          end else if (op_lkp) begin
            skey  <= req_key;
            ptr   <= '0;
            state <= SCAN;
          end
        end
      end else begin
        if (last) begin
          state       <= IDLE;
          done        <= 1'b1;
          hit         <= match;
          hit_idx     <= match ? ptr : '0;
          lookup_clks <= CNT_W'(ptr) + CNT_W'(1);
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_busy_after_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> !req_ready);

  p_update_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op != 2'd0) |=> (req_ready && !done));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hit) && $stable(hit_idx) && $stable(lookup_clks)));

  p_miss_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));

  p_clks_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lookup_clks >= CNT_W'(1) && lookup_clks <= CNT_W'(DEPTH)));

  p_hit_clks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (lookup_clks == CNT_W'(hit_idx) + CNT_W'(1)));

endmodule

// File: tb/scan_cam_test.sv
module scan_cam_test;
  localparam int KEY_W = 4;
  localparam int DEPTH = 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_op = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [KEY_W-1:0] req_key = '0;
  logic             done, hit;
  logic [IDX_W-1:0] hit_idx;
  logic [CNT_W-1:0] lookup_clks;

  always #5 clk = ~clk;

  scan_cam #(.KEY_W(KEY_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_idx(req_idx), .req_key(req_key), .done(done),
    .hit(hit), .hit_idx(hit_idx), .lookup_clks(lookup_clks)
  );

  int vectors = 0;
  int fails = 0;

  // behavioural reference
  bit m_v [DEPTH];
  int m_k [DEPTH];
  int m_top, m_cnt;
  bit e_done, e_hit, p_hit;
  int e_idx, e_clks, p_idx, p_clks;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_top = 0; m_cnt = 0;
      e_done = 0; e_hit = 0; e_idx = 0; e_clks = 0;
    end else begin
      e_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          e_done = 1; e_hit = p_hit; e_idx = p_idx; e_clks = p_clks;
        end
      end else if (req_valid) begin
        if (req_op == 2'd1) begin
          m_v[req_idx] = 1; m_k[req_idx] = int'(req_key);
          if (int'(req_idx) > m_top) m_top = int'(req_idx);
        end else if (req_op >= 2'd2) begin
          m_v[req_idx] = 0;
        end else begin
          p_hit = 0; p_idx = 0; p_clks = m_top + 1;
          for (int i = DEPTH - 1; i >= 0; i--)
            if (m_v[i] && m_k[i] == int'(req_key)) begin
              p_hit = 1; p_idx = i; p_clks = i + 1;
            end
          m_cnt = p_clks;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 done", int'(done), int'(e_done));
    chk("R6 req_ready", int'(req_ready), int'(m_cnt == 0));
    chk("R2/R7/R8 hit", int'(hit), int'(e_hit));
    chk("R3 hit_idx", int'(hit_idx), e_idx);
    chk("R5 lookup_clks", int'(lookup_clks), e_clks);
  endtask

  task automatic step(bit v, int op, int idx, int key);
    @(negedge clk);
    compare_all();
    req_valid = v;
    req_op = 2'(op);
    req_idx = IDX_W'(idx);
    req_key = KEY_W'(key);
  endtask

  task automatic op_then_idle(int op, int idx, int key);
    step(1, op, idx, key);
    repeat (DEPTH + 2) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 hit in reset", int'(hit), 0);
    chk("R1 hit_idx in reset", int'(hit_idx), 0);
    chk("R1 clks in reset", int'(lookup_clks), 0);
    rst_n = 1'b1;
    // R1: empty array misses in one clock
    op_then_idle(0, 5, 3);
    op_then_idle(1, 3, 5);          // R7 write
    op_then_idle(1, 1, 5);          // duplicate key, lower index
    op_then_idle(0, 0, 5);          // R3 lowest index: 1, 2 clocks
    op_then_idle(2, 1, 0);          // R7 invalidate
    op_then_idle(0, 0, 5);          // R2 invalid skipped: idx 3, 4 clocks
    op_then_idle(3, 6, 0);          // invalidate via code 3 on empty slot
    op_then_idle(1, 7, 9);
    op_then_idle(0, 0, 2);          // R5 miss, full scan 8 clocks
    op_then_idle(0, 0, 9);          // hit at 7, 8 clocks
    op_then_idle(1, 3, 9);          // R8 write leaves results alone
    op_then_idle(0, 0, 9);          // now idx 3
    for (int n = 0; n < 6000; n++) begin
      int r = int'($urandom_range(0, 9));
      step(r < 7, int'($urandom_range(0, 2)), int'($urandom_range(0, DEPTH - 1)),
           int'($urandom_range(0, 15)));
    end
    repeat (DEPTH + 2) step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule